// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block generates the system reset for a processor subsystem. Three things request a reset. The first is a supply-good flag, which comes already synchronised from an external voltage comparator. The second is an active-low push-button or manual reset line. The third is a watchdog that fires when software stops toggling its kick input. Every reset request is stretched by a programmable hold time, so that downstream logic always sees a reset of at least that length. The reset is driven on two pins with opposite polarities.

The watchdog counts only while reset is released and is held clear while reset is asserted. Either a rising or a falling edge on the kick input clears it. A kick line stuck at one level therefore gives a repeating reset, whose period is the watchdog timeout plus the hold time. Kick pulses shorter than a small filter length are treated as noise. A disable input stands in for an unconnected kick pin. Both timeouts are parameters given in clock ticks, so the nominal 200 ms hold and 1.6 s watchdog can be scaled down for simulation.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok_i` is 0 at a rising clock edge, `rst_o` is 1 after that edge.
- R2: Once every reset request has cleared, `rst_o` stays 1 for exactly `RST_TICKS` more clock edges. It falls on edge L+`RST_TICKS`, where L is the last edge that sampled a request.
- R3: A new request during the hold time restarts the full `RST_TICKS` hold, counted from the last edge of the new request.
- R4: `man_rst_n_i` passes through a two-flop synchroniser. Driving it to 0 asserts `rst_o` on the third edge. Returning it to 1 releases `rst_o` `RST_TICKS`+2 edges later.
- R5: While the watchdog is enabled and sees no valid kick edge, `rst_o` falls and rises again after exactly `WD_TICKS` edges. This repeats with a period of `WD_TICKS`+`RST_TICKS` edges.
- R6: A kick level that holds for at least `FILT_LEN` synchronised cycles counts as a valid edge (rising or falling) and clears the watchdog. Kicks every 10 cycles keep `rst_o` at 0 indefinitely.
- R7: A kick pulse of one clock cycle is ignored. Expiry timing is the same as with no kick at all.
- R8: While `wd_disable_i` is 1, the watchdog is held clear and never asserts reset.
- R9: `rst_n_o` is always the complement of `rst_o`.
- R10: While `rst_n` is low, `rst_o` is 1. After `rst_n` is released, `rst_o` stays 1 for `RST_TICKS` edges when no request is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| supply_ok_i | input | 1 | Synchronised supply-good flag, 1 = valid |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| wd_kick_i | input | 1 | Watchdog kick; any filtered edge clears the watchdog |
| wd_disable_i | input | 1 | 1 = watchdog held clear and disabled |
| rst_n_o | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high |

## Verification
The supply flag takes effect on the first edge, and its release shows `RST_TICKS` edges after the last low sample. The manual line adds two synchroniser edges in both directions. A watchdog expiry lands exactly `WD_TICKS` edges after the edge that released reset or cleared the disable. The driver records the edge count when it changes an input, works out the edge on which each output level is due from these latencies, and queues the expected level for the cycle just before and just after that transition. The monitor samples on falling clock edges and compares each queued item when its cycle comes up.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Width needed to hold values 0..n inclusive.
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/kick_filt.sv
module kick_filt #(
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic edge_o
);
  import sup_pkg::*;
  localparam int FCW = cnt_w(FILT_LEN);

  logic [FCW-1:0] fcnt_q, fcnt_d;
  logic           lvl_q, lvl_d;
  logic           edge_q, edge_d;

  always_comb begin
    fcnt_d = fcnt_q;
    lvl_d  = lvl_q;
    edge_d = 1'b0;
    if (lvl_i == lvl_q) begin
      fcnt_d = '0;
    end else if (fcnt_q == FCW'(FILT_LEN - 1)) begin
      fcnt_d = '0;
      lvl_d  = lvl_i;
      edge_d = 1'b1;
    end else begin
      fcnt_d = fcnt_q + FCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      lvl_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      lvl_q  <= lvl_d;
      edge_q <= edge_d;
    end
  end

  assign edge_o = edge_q;

  // R7
  filt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q < FCW'(FILT_LEN));
  // R6
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q |=> !edge_q);
endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
  parameter int WD_TICKS = 80_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic dis_i,
  input  logic edge_i,
  output logic expire_o
);
  import sup_pkg::*;
  localparam int WCW = cnt_w(WD_TICKS);

  logic [WCW-1:0] cnt_q, cnt_d;
  logic           wrap;
  logic           hold_clr;

  assign hold_clr = clr_i | dis_i | edge_i;
  assign wrap     = (cnt_q == WCW'(WD_TICKS - 1));

  always_comb begin
    if (hold_clr || wrap) cnt_d = '0;
    else                  cnt_d = cnt_q + WCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = wrap & ~hold_clr;

  // R8
  wd_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |=> (cnt_q == '0));
  // R5
  wd_rst_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int RST_TICKS = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic act_o
);
  import sup_pkg::*;
  localparam int RCW = cnt_w(RST_TICKS);

  logic [RCW-1:0] cnt_q, cnt_d;
  logic           act_q, act_d;

  always_comb begin
    if (hold_i) begin
      cnt_d = RCW'(RST_TICKS);
      act_d = 1'b1;
    end else if (cnt_q > RCW'(1)) begin
      cnt_d = cnt_q - RCW'(1);
      act_d = 1'b1;
    end else begin
      cnt_d = '0;
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RCW'(RST_TICKS);
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;

  // R2
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !hold_i && cnt_q > RCW'(1)) |=> act_q);
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == RCW'(RST_TICKS)));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int RST_TICKS = 10_000_000,
  parameter int WD_TICKS  = 80_000_000,
  parameter int FILT_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic man_rst_n_i,
  input  logic wd_kick_i,
  input  logic wd_disable_i,
  output logic rst_n_o,
  output logic rst_o
);
  logic [1:0] sync_q;
  logic       man_s;
  logic       kick_s;
  logic       kick_edge;
  logic       wd_exp;
  logic       hold;
  logic       act;

  // bit 0: manual reset (idle high), bit 1: kick
  sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({wd_kick_i, man_rst_n_i}),
    .q_o   (sync_q)
  );
  assign man_s  = sync_q[0];
  assign kick_s = sync_q[1];

  kick_filt #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (kick_s),
    .edge_o (kick_edge)
  );

  wd_timer #(.WD_TICKS(WD_TICKS)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (act),
    .dis_i    (wd_disable_i),
    .edge_i   (kick_edge),
    .expire_o (wd_exp)
  );

  assign hold = ~supply_ok_i | ~man_s | wd_exp;

  rst_stretch #(.RST_TICKS(RST_TICKS)) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (hold),
    .act_o  (act)
  );

  assign rst_o   = act;
  assign rst_n_o = ~act;

  // R1
  supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> rst_o);
  // R5
  wd_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_exp |=> rst_o);
  // R4
  man_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !man_s |=> rst_o);
endmodule

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
  localparam int R  = 20;
  localparam int WD = 50;
  localparam int FL = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, man_n, kick, wd_dis;
  logic rst_n_o, rst_o;

  always #5 clk = ~clk;

  rst_supervisor #(.RST_TICKS(R), .WD_TICKS(WD), .FILT_LEN(FL)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok_i  (supply_ok),
    .man_rst_n_i  (man_n),
    .wd_kick_i    (kick),
    .wd_disable_i (wd_dis),
    .rst_n_o      (rst_n_o),
    .rst_o        (rst_o)
  );

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int c, input logic v, input string t);
    exp_t e;
    e.cyc = c; e.val = v; e.tag = t;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rst_n_o !== ~rst_o) begin
        n_run++; n_fail++;
        $display("FAIL R9 cyc %0d: rst_n_o=%b rst_o=%b expected complement",
                 cyc, rst_n_o, rst_o);
      end
    end
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (e.cyc != cyc || rst_o !== e.val) begin
        n_fail++;
        $display("FAIL %s cyc %0d (due %0d): rst_o=%b expected %b",
                 e.tag, cyc, e.cyc, rst_o, e.val);
      end
    end
  end

  task automatic step(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n, m, d, l, fall;
    rst_n = 1'b0; supply_ok = 1'b1; man_n = 1'b1; kick = 1'b0; wd_dis = 1'b1;
    step(3);
    // R10: asserted while logic reset is held
    n_run++;
    if (rst_o !== 1'b1 || rst_n_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 in reset: rst_o=%b rst_n_o=%b expected 1/0", rst_o, rst_n_o);
    end
    rst_n = 1'b1;
    n = cyc;
    push(n + R - 1, 1'b1, "R10");
    push(n + R,     1'b0, "R10");
    drain();

    // R1/R2: supply drop
    step(2);
    supply_ok = 1'b0; n = cyc;
    push(n + 1, 1'b1, "R1");
    step(5);
    supply_ok = 1'b1; m = cyc;
    push(m + R - 1, 1'b1, "R2");
    push(m + R,     1'b0, "R2");
    drain();

    // R3: second drop in the middle of the hold time
    supply_ok = 1'b0; step(3);
    supply_ok = 1'b1; m = cyc;
    step(10);
    supply_ok = 1'b0; step(1);
    supply_ok = 1'b1; l = cyc;
    push(m + R,     1'b1, "R3");
    push(l + R - 1, 1'b1, "R3");
    push(l + R,     1'b0, "R3");
    drain();

    // R4: manual reset
    step(2);
    man_n = 1'b0; n = cyc;
    push(n + 2, 1'b0, "R4");
    push(n + 3, 1'b1, "R4");
    step(6);
    man_n = 1'b1; m = cyc;
    push(m + 2 + R - 1, 1'b1, "R4");
    push(m + 2 + R,     1'b0, "R4");
    drain();

    // R5: stuck kick, watchdog enabled
    step(3);
    wd_dis = 1'b0; n = cyc;
    push(n + WD - 1,          1'b0, "R5");
    push(n + WD,              1'b1, "R5");
    push(n + WD + R - 1,      1'b1, "R5");
    push(n + WD + R,          1'b0, "R5");
    push(n + 2*WD + R - 1,    1'b0, "R5");
    push(n + 2*WD + R,        1'b1, "R5");
    push(n + 2*WD + 2*R,      1'b0, "R5");
    fall = n + 2*WD + 2*R;
    drain();

    // R6: regular kicks hold reset off
    while (cyc < fall + 2) @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      kick = ~kick;
      push(cyc + 9, 1'b0, "R6");
      step(10);
    end
    drain();

    // R7: single-cycle glitches do not kick
    wd_dis = 1'b1; step(10);
    wd_dis = 1'b0; n = cyc;
    push(n + WD - 1, 1'b0, "R7");
    push(n + WD,     1'b1, "R7");
    step(3);
    for (int k = 0; k < 4; k++) begin
      kick = ~kick; step(1);
      kick = ~kick; step(9);
    end
    drain();

    // R8: disabled watchdog never fires
    wd_dis = 1'b1;
    d = n + WD + R;
    push(d, 1'b0, "R8");
    for (int k = 1; k <= 6; k++) push(d + k * 25, 1'b0, "R8");
    drain();

    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 20000) @(negedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung at cyc %0d, expected completion", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule